// File: doc/BRIEF.md
# GPIO Input Qualifier and Interrupt Router

This block conditions a bank of sixteen general-purpose input pins and routes two of them to external interrupt lines. Every pin is first brought into the clock domain by a two-flop synchronizer. It then passes through a filter chosen per pin: synchronizer only, or an agreement filter. The agreement filter accepts a new level only after three or six consecutive samples have agreed on it. The filtered (qualified) levels are presented on a data output.

The agreement filters do not sample on every clock. Each group of eight pins has its own sampling-period field: a value of 0 samples on every clock, and a value N samples once every 2·N clocks, which gives up to 510 clocks between samples. Two interrupt channels each pick any pin by index. A channel watches the qualified level of that pin for a rising or a falling edge and, when it is enabled, emits a one-cycle interrupt pulse.

Configuration is loaded through a simple write port: a write strobe, an address and a data word. A written value takes effect on the following clock.

Top module: `gpio_qual_irq`

## Requirements
- R1: After reset, `qual_data` and `irq` are all zero, every pin is in synchronize-only mode, both sampling periods are 0, and both channels are disabled with source 0 and polarity 0.
- R2: A write with `wr_en`=1 is decoded as follows, and takes effect from the next clock:
  - address 0 loads the pin modes, with pin i at data bits [2i+1:2i];
  - address 1 loads the periods, with group g at bits [8g+7:8g];
  - address 2+c loads channel c, with source at bits [4:0], polarity at bit 5 and enable at bit 6;
  - writes to any other address change nothing.
- R3: In mode 0 or 3 (synchronize only), `qual_data[i]` equals the pin level three clocks earlier. In every mode, any new qualified level equals the pin level sampled three clocks before that change.
- R4: In mode 1 the qualified level changes only after 3 consecutive equal samples of the synchronized pin. In mode 2 it needs 6. A differing sample restarts the count, so shorter pulses are rejected. With period 0, a clean pin change appears 5 clocks later in mode 1 and 8 clocks later in mode 2.
- R5: With a period field of 0, the filter samples every clock. With a value N, it samples once every 2·N clocks. A filtered pin changes only in a cycle that follows a sample.
- R6: Pins 0–7 use the first period field, and pins 8–15 use the second.
- R7: Polarity 1 detects a rising edge and polarity 0 a falling edge of the selected pin's qualified level. The pulse is high for exactly one clock, in the clock after the qualified level changes.
- R8: A channel whose enable bit is 0 produces no pulse.
- R9: Source values 0–15 select that pin, for example pin 14 or 15. Values 16–31 select no pin and never pulse.
- R10: Changing a channel's source select does not by itself produce a pulse, even when the old and new pins have different levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 16 | Raw asynchronous pin levels |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration register address |
| wr_data | input | 32 | Configuration write data |
| qual_data | output | 16 | Qualified level of each pin |
| irq | output | 2 | One-cycle interrupt pulse for each channel |

## Verification
Two functions can fall in the same cycle:
- A write to a channel's source select can arrive in the very cycle that the old pin, or the new pin, changes its qualified level. A naive edge detector would then compare levels from two different pins.
- A period write can land between two samples of an agreement filter that is partway through its count.

The random phase rewrites channel and period settings while pins toggle sparsely, and a directed case switches a falling-edge channel from a high pin to a low pin. Each is judged cycle by cycle against a bench model built from the requirements, which expects no pulse for a source switch and a count that continues across a period change.

// File: rtl/gpq_pkg.sv
package gpq_pkg;
    typedef enum logic [1:0] {
        QM_SYNC     = 2'd0,
        QM_THREE    = 2'd1,
        QM_SIX      = 2'd2,
        QM_SYNC_ALT = 2'd3
    } qmode_e;

    localparam int ADDR_MODE   = 0;
    localparam int ADDR_PERIOD = 1;
    localparam int ADDR_CHAN0  = 2;

    // agreement count needed by a mode, 0 = pass straight through
    function automatic logic [2:0] need_of(qmode_e m);
        case (m)
            QM_THREE: need_of = 3'd3;
            QM_SIX:   need_of = 3'd6;
            default:  need_of = 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/gpq_tick.sv
module gpq_tick #(
    parameter int PERW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PERW-1:0] per,
    output logic            tick
);
    localparam int CW = PERW + 1;

    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] lim;

    always_comb begin
        lim   = (per == '0) ? '0 : ({per, 1'b0} - CW'(1));
        tick  = (cnt_q >= lim);
        cnt_d = tick ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/gpq_filter.sv
module gpq_filter
    import gpq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] mode,
    input  logic       tick,
    output logic       q
);
    typedef struct packed {
        logic [1:0] sy;
        logic       last;
        logic [2:0] run;
        logic       q;
    } fstate_t;

    fstate_t r_q, r_d;
    logic       s;
    logic [2:0] need;
    logic [2:0] run_n;

    always_comb begin
        r_d    = r_q;
        r_d.sy = {r_q.sy[0], pin};
        s      = r_q.sy[1];
        need   = need_of(qmode_e'(mode));
        run_n  = r_q.run;
        if (need == 3'd0) begin
            r_d.q = s;
        end else if (tick) begin
            if (s == r_q.last) run_n = (r_q.run == 3'd7) ? 3'd7 : r_q.run + 3'd1;
            else               run_n = 3'd1;
            r_d.run  = run_n;
            r_d.last = s;
            if (run_n >= need) r_d.q = s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign q = r_q.q;
endmodule

// File: rtl/gpq_chan.sv
module gpq_chan #(
    parameter int NPIN = 16,
    parameter int SELW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] qual,
    input  logic [SELW-1:0] src,
    input  logic            pol,
    input  logic            en,
    output logic            irq
);
    localparam int IDXW = $clog2(NPIN);

    typedef struct packed {
        logic            prev;
        logic [SELW-1:0] lsrc;
        logic            irq;
    } cstate_t;

    cstate_t c_q, c_d;
    logic lvl, edge_seen;

    always_comb begin
        lvl       = (32'(src) < NPIN) ? qual[src[IDXW-1:0]] : 1'b0;
        edge_seen = pol ? (lvl & ~c_q.prev) : (~lvl & c_q.prev);
        c_d.irq   = en && (c_q.lsrc == src) && edge_seen;
        c_d.prev  = lvl;
        c_d.lsrc  = src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign irq = c_q.irq;
endmodule

// File: rtl/gpio_qual_irq.sv
module gpio_qual_irq
    import gpq_pkg::*;
#(
    parameter int NPIN = 16,
    parameter int GRP  = 8,
    parameter int NCH  = 2,
    parameter int PERW = 8,
    parameter int SELW = 5,
    parameter int AW   = 3,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_in,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    output logic [NPIN-1:0] qual_data,
    output logic [NCH-1:0]  irq
);
    localparam int NGRP = NPIN / GRP;
    localparam int QSW  = 2 * NPIN;
    localparam int PSW  = NGRP * PERW;
    localparam int CHW  = SELW + 2;

    typedef struct packed {
        logic [QSW-1:0]     qsel;
        logic [PSW-1:0]     per;
        logic [NCH*CHW-1:0] chan;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    logic [QSW-1:0]      qsel_w;
    logic [NGRP-1:0]     tick_w;
    logic [NCH*SELW-1:0] chan_src_w;
    logic [NCH-1:0]      chan_pol_w;
    logic [NCH-1:0]      chan_en_w;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_addr == AW'(ADDR_MODE))   cfg_d.qsel = wr_data[QSW-1:0];
            if (wr_addr == AW'(ADDR_PERIOD)) cfg_d.per  = wr_data[PSW-1:0];
            for (int c = 0; c < NCH; c++) begin
                if (wr_addr == AW'(ADDR_CHAN0 + c)) cfg_d.chan[c*CHW +: CHW] = wr_data[CHW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign qsel_w = cfg_q.qsel;

    for (genvar g = 0; g < NGRP; g++) begin : g_tick
        gpq_tick #(.PERW(PERW)) u_tick (
            .clk  (clk),
            .rst_n(rst_n),
            .per  (cfg_q.per[g*PERW +: PERW]),
            .tick (tick_w[g])
        );
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        gpq_filter u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pin_in[i]),
            .mode (qsel_w[2*i +: 2]),
            .tick (tick_w[i / GRP]),
            .q    (qual_data[i])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign chan_src_w[c*SELW +: SELW] = cfg_q.chan[c*CHW +: SELW];
        assign chan_pol_w[c]              = cfg_q.chan[c*CHW + SELW];
        assign chan_en_w[c]               = cfg_q.chan[c*CHW + SELW + 1];

        gpq_chan #(.NPIN(NPIN), .SELW(SELW)) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .qual (qual_data),
            .src  (chan_src_w[c*SELW +: SELW]),
            .pol  (chan_pol_w[c]),
            .en   (chan_en_w[c]),
            .irq  (irq[c])
        );
    end
endmodule

// File: rtl/gpq_checker.sv
module gpq_checker #(
    parameter int NPIN = 16,
    parameter int GRP  = 8,
    parameter int NCH  = 2,
    parameter int SELW = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NPIN-1:0]        pin_in,
    input logic [NPIN-1:0]        qual_data,
    input logic [NCH-1:0]         irq,
    input logic [2*NPIN-1:0]      mode_vec,
    input logic [NPIN/GRP-1:0]    tick_vec,
    input logic [NCH*SELW-1:0]    src_vec,
    input logic [NCH-1:0]         en_vec
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin_chk
        assert_qual_from_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (qual_data[i] != $past(qual_data[i])) |-> (qual_data[i] == $past(pin_in[i], 3)));

        assert_filter_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ((qual_data[i] != $past(qual_data[i])) &&
             (($past(mode_vec[2*i +: 2]) == 2'd1) || ($past(mode_vec[2*i +: 2]) == 2'd2)))
            |-> $past(tick_vec[i / GRP]));
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan_chk
        assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |-> $past(en_vec[c]));

        assert_irq_valid_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |-> (32'($past(src_vec[c*SELW +: SELW])) < NPIN));

        assert_irq_source_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |-> ($past(src_vec[c*SELW +: SELW]) == $past(src_vec[c*SELW +: SELW], 2)));
    end
endmodule

bind gpio_qual_irq gpq_checker #(
    .NPIN(NPIN), .GRP(GRP), .NCH(NCH), .SELW(SELW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .qual_data(qual_data),
    .irq      (irq),
    .mode_vec (qsel_w),
    .tick_vec (tick_w),
    .src_vec  (chan_src_w),
    .en_vec   (chan_en_w)
);

// File: tb/gpio_qual_irq_tb.sv
module gpio_qual_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pins = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] qual_data;
    logic [1:0]  irq;

    int nchk = 0, nbad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_qual_irq u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pins), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .qual_data(qual_data), .irq(irq)
    );

    // ---------------- reference model built from the requirements ----------
    logic [15:0] m_ff1, m_ff2, m_last, m_q;
    int          m_run [16];
    int          m_mode[16];
    int          m_per [2];
    int          m_cnt [2];
    int          m_src [2];
    logic [1:0]  m_pol, m_en, m_prev, m_irq;
    int          m_lsrc[2];
    logic [1:0]  t_smp;
    int          t_r, t_need;
    logic        t_lvl, t_edge;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ff1 <= '0; m_ff2 <= '0; m_last <= '0; m_q <= '0;
            m_pol <= '0; m_en <= '0; m_prev <= '0; m_irq <= '0;
            for (int i = 0; i < 16; i++) begin m_run[i] <= 0; m_mode[i] <= 0; end
            for (int g = 0; g < 2; g++) begin
                m_per[g] <= 0; m_cnt[g] <= 0; m_src[g] <= 0; m_lsrc[g] <= 0;
            end
        end else begin
            for (int g = 0; g < 2; g++) begin
                t_smp[g] = (m_per[g] == 0) || (m_cnt[g] >= 2 * m_per[g] - 1);
                m_cnt[g] <= t_smp[g] ? 0 : m_cnt[g] + 1;
            end
            for (int i = 0; i < 16; i++) begin
                m_ff1[i] <= pins[i];
                m_ff2[i] <= m_ff1[i];
                t_need = (m_mode[i] == 1) ? 3 : (m_mode[i] == 2) ? 6 : 0;
                if (t_need == 0) m_q[i] <= m_ff2[i];
                else if (t_smp[i / 8]) begin
                    t_r = (m_ff2[i] == m_last[i]) ? ((m_run[i] >= 7) ? 7 : m_run[i] + 1) : 1;
                    m_run[i]  <= t_r;
                    m_last[i] <= m_ff2[i];
                    if (t_r >= t_need) m_q[i] <= m_ff2[i];
                end
            end
            for (int c = 0; c < 2; c++) begin
                t_lvl  = (m_src[c] < 16) ? m_q[m_src[c]] : 1'b0;
                t_edge = m_pol[c] ? (t_lvl && !m_prev[c]) : (!t_lvl && m_prev[c]);
                m_irq[c]  <= m_en[c] && (m_lsrc[c] == m_src[c]) && t_edge;
                m_prev[c] <= t_lvl;
                m_lsrc[c] <= m_src[c];
            end
            if (wr_en) begin
                if (wr_addr == 3'd0) for (int i = 0; i < 16; i++) m_mode[i] <= int'(wr_data[2*i +: 2]);
                if (wr_addr == 3'd1) begin m_per[0] <= int'(wr_data[7:0]); m_per[1] <= int'(wr_data[15:8]); end
                for (int c = 0; c < 2; c++) if (wr_addr == 3'(2 + c)) begin
                    m_src[c] <= int'(wr_data[4:0]); m_pol[c] <= wr_data[5]; m_en[c] <= wr_data[6];
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    int pc0 = 0, pc1 = 0;

    // one clock; compare with the model at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check("R3 R4 R5 R6 qual vs model", 32'(qual_data), 32'(m_q));
        check("R7 R8 R9 R10 irq vs model", 32'(irq), 32'(m_irq));
        pc0 += int'(irq[0]);
        pc1 += int'(irq[1]);
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset qual", 32'(qual_data), 32'h0);
        check("R1 reset irq", 32'(irq), 32'h0);

        // R1 default mode is synchronize only; R3 latency of three clocks
        pins[0] = 1'b1;
        steps(2); check("R3 sync before 3 clocks", 32'(qual_data[0]), 32'h0);
        step();   check("R3 sync after 3 clocks", 32'(qual_data[0]), 32'h1);
        pins[0] = 1'b0; steps(3);
        check("R1 R3 sync falls", 32'(qual_data[0]), 32'h0);

        // R2 R4: pin1 three-sample, pin2 six-sample
        wr(3'd0, 32'h0000_0024);
        pins[1] = 1'b1;
        steps(4); check("R4 three-sample before 5", 32'(qual_data[1]), 32'h0);
        step();   check("R4 three-sample at 5", 32'(qual_data[1]), 32'h1);
        pins[1] = 1'b0; steps(2); pins[1] = 1'b1; steps(10);
        check("R4 short low rejected", 32'(qual_data[1]), 32'h1);
        pins[1] = 1'b0; steps(8);
        check("R4 three-sample falls", 32'(qual_data[1]), 32'h0);
        pins[2] = 1'b1;
        steps(7); check("R4 six-sample before 8", 32'(qual_data[2]), 32'h0);
        step();   check("R4 six-sample at 8", 32'(qual_data[2]), 32'h1);
        pins[2] = 1'b0; steps(10);
        pins[2] = 1'b1; steps(5); pins[2] = 1'b0; steps(12);
        check("R4 five-clock pulse rejected by six-sample", 32'(qual_data[2]), 32'h0);

        // R5 period 2 on group 0: sample every 4 clocks
        wr(3'd1, 32'h0000_0002);
        pins[1] = 1'b1; steps(7); pins[1] = 1'b0; steps(20);
        check("R5 seven-clock pulse spans two samples only", 32'(qual_data[1]), 32'h0);
        pins[1] = 1'b1; steps(20);
        check("R5 held level accepted", 32'(qual_data[1]), 32'h1);
        pins[1] = 1'b0; steps(20);

        // R6 group periods: group0 every clock, group1 every 510 clocks
        wr(3'd1, 32'h0000_FF00);
        wr(3'd0, 32'h0100_0064);
        pins[3] = 1'b1; pins[12] = 1'b1; steps(10);
        check("R6 pin3 uses first field", 32'(qual_data[3]), 32'h1);
        check("R6 pin12 uses second field", 32'(qual_data[12]), 32'h0);
        steps(2100);
        check("R6 pin12 accepted after slow samples", 32'(qual_data[12]), 32'h1);
        wr(3'd1, 32'h0); wr(3'd0, 32'h0);
        pins = '0; steps(6);

        // R7 R9: ch0 pin14 rising, ch1 pin15 falling
        wr(3'd2, 32'h0000_006E);
        wr(3'd3, 32'h0000_004F);
        steps(2);
        pins[14] = 1'b1;
        steps(3); check("R7 no pulse before qualified change", 32'(irq[0]), 32'h0);
        step();   check("R7 R9 pulse from pin14", 32'(irq[0]), 32'h1);
        step();   check("R7 pulse lasts one clock", 32'(irq[0]), 32'h0);
        pc1 = 0; pins[15] = 1'b1; steps(8);
        check("R7 rising ignored by falling channel", 32'(pc1), 32'h0);
        pc1 = 0; pins[15] = 1'b0; steps(8);
        check("R7 R9 falling pulse from pin15", 32'(pc1), 32'h1);
        pc0 = 0; pins[14] = 1'b0; steps(8);
        check("R7 falling ignored by rising channel", 32'(pc0), 32'h0);

        // R8 disabled channel
        wr(3'd2, 32'h0000_002E);
        pc0 = 0;
        for (int k = 0; k < 4; k++) begin pins[14] = ~pins[14]; steps(5); end
        check("R8 disabled channel silent", 32'(pc0), 32'h0);

        // R10 source switch between pins at different levels
        pins[14] = 1'b1; pins[15] = 1'b0;
        wr(3'd2, 32'h0000_004E);
        steps(8);
        pc0 = 0;
        wr(3'd2, 32'h0000_004F);
        steps(8);
        check("R10 source switch makes no pulse", 32'(pc0), 32'h0);
        pc0 = 0; pins[15] = 1'b1; steps(6); pins[15] = 1'b0; steps(6);
        check("R10 new source still detects", 32'(pc0), 32'h1);

        // R9 unmapped source
        wr(3'd2, 32'h0000_0074);
        pc0 = 0;
        for (int k = 0; k < 4; k++) begin pins = ~pins; steps(6); end
        check("R9 source 20 never pulses", 32'(pc0), 32'h0);

        // R2 unmapped address leaves modes untouched
        wr(3'd5, 32'hFFFF_FFFF);
        pins[0] = 1'b1; steps(3);
        check("R2 write to address 5 ignored", 32'(qual_data[0]), 32'h1);
        pins[0] = 1'b0; steps(3);

        // random phase
        for (int rnd = 0; rnd < 40; rnd++) begin
            wr(3'd0, $urandom);
            wr(3'd1, $urandom & 32'h0000_0303);
            wr(3'd2, $urandom & 32'h0000_007F);
            wr(3'd3, $urandom & 32'h0000_007F);
            for (int k = 0; k < 150; k++) begin
                pins = pins ^ 16'($urandom & $urandom & $urandom);
                if ($urandom % 25 == 0) wr(3'(2 + $urandom % 2), $urandom & 32'h0000_007F);
                else step();
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule